// File: doc/BRIEF.md
# Adaptive Harmonic Interference Canceller

This block sits in the digital baseband behind a four-phase harmonic-rejection mixer. Each clock it takes one real sample from each of the 0°, 45°, 90° and 135° converter streams. It pairs the 0°/90° streams into the main complex sample and the 45°/135° streams into a second complex sample. It turns the second sample by −45° and subtracts it from the main one. The wanted signal is common to both pairs, so it drops out of that difference, and what remains is a reference that holds only the leftover harmonic image response.

Two adaptive complex weights scale and phase-align the reference. One weight acts on the reference itself and the other on its conjugate, so both plain and mirrored residues can be removed. Their sum is the interference estimate, which is subtracted from the main sample to give the cleaned output. After every accepted sample, a least-mean-squares step moves both weights so that the correlation between the reference and the output decays. The step size is a programmable power of two. A clear input zeroes the weights and a freeze input holds them, while the output path keeps running.

Top module: `harm_canceller`

## Requirements
- R1: The main sample is r = p000 + j·p090. While both weights are zero, out_i equals the 0° sample and out_q equals the 90° sample of the same input cycle, whatever the 45°/135° inputs are.
- R2: The reference is v = r − t, where t = round((p045 + j·p135)(1 − j)·23170 / 2^15). Rounding adds 2^14 before a floor shift by 15. So t_re comes from (p045 + p135) and t_im from (p135 − p045).
- R3: The estimate is y = floor((w1·v + w2·conj(v)) / 2^16), taken per component. Weights are two's-complement numbers with 16 fractional bits. The unclamped error is e = r − y.
- R4: out_i and out_q are the real and imaginary parts of e, clamped to the range −2^(OUT_W−1) to 2^(OUT_W−1)−1.
- R5: After each accepted sample, w1 gains floor(e·conj(v) / 2^(GRAD_SHIFT+mu)) and w2 gains floor(e·v / 2^(GRAD_SHIFT+mu)), per component. The update uses that sample's own unclamped e and v, and the next sample sees the new weights.
- R6: After each update, every weight component is clamped to the signed W_W-bit range.
- R7: If clear is high with a sample, that sample's output still uses the old weights, and every later sample sees zero weights. Clear with in_valid low also zeroes the weights.
- R8: If freeze is high with a sample, its output is computed normally and the weights stay unchanged.
- R9: out_valid goes high exactly two rising edges after a cycle with in_valid high, and back-to-back samples give back-to-back results. After reset, out_valid and both outputs are zero.
- R10: A cycle with in_valid low changes neither the weights (unless clear is high) nor out_i/out_q, which keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The four phase samples are valid this cycle |
| p000 | input | IN_W | 0° stream sample, signed |
| p045 | input | IN_W | 45° stream sample, signed |
| p090 | input | IN_W | 90° stream sample, signed |
| p135 | input | IN_W | 135° stream sample, signed |
| mu_shift | input | MU_W | Extra right shift of the update step |
| hold_w | input | 1 | Freeze the weights for this sample |
| clr_w | input | 1 | Zero the weights after this cycle |
| out_valid | output | 1 | out_i/out_q carry a new result |
| out_i | output | OUT_W | Cleaned output, real part |
| out_q | output | OUT_W | Cleaned output, imaginary part |

## Verification
The bench builds the block with IN_W 12, W_W 18 and GRAD_SHIFT 12, and with OUT_W lowered to 14. With 14 output bits, a frozen pair of saturated weights acting on a large reference drives the error past the output range, so the clamp can be checked. With a shift of 12 and mu_shift 0, a steady reference that is much weaker than the main sample pushes both weights to their 18-bit limits within about a thousand samples. The bench follows the full arithmetic, including floors, rounding and both clamps, sample by sample, so every output is compared bit for bit.

// File: rtl/harm_pkg.sv
package harm_pkg;
  typedef logic signed [63:0] wide_t;

  localparam int    ROT_FRAC = 15;
  localparam wide_t ROT_K    = 64'sd23170;

  function automatic wide_t lim_hi(input int unsigned n);
    return (wide_t'(1) <<< (n - 1)) - wide_t'(1);
  endfunction

  function automatic wide_t lim_lo(input int unsigned n);
    return -(wide_t'(1) <<< (n - 1));
  endfunction

  // s / sqrt(2), rounded half up
  function automatic wide_t scale_isqrt2(input wide_t s);
    return (s * ROT_K + (wide_t'(1) <<< (ROT_FRAC - 1))) >>> ROT_FRAC;
  endfunction
endpackage

// File: rtl/harm_ref_gen.sv
module harm_ref_gen
  import harm_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int MU_W = 4,
  parameter int VW   = IN_W + 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic signed [IN_W-1:0] p000,
  input  logic signed [IN_W-1:0] p045,
  input  logic signed [IN_W-1:0] p090,
  input  logic signed [IN_W-1:0] p135,
  input  logic [MU_W-1:0]        mu_shift,
  input  logic                   hold_w,
  input  logic                   clr_w,
  output logic                   s_valid,
  output logic                   s_hold,
  output logic                   s_clr,
  output logic [MU_W-1:0]        s_mu,
  output logic signed [IN_W-1:0] r_re,
  output logic signed [IN_W-1:0] r_im,
  output logic signed [VW-1:0]   v_re,
  output logic signed [VW-1:0]   v_im
);
  logic signed [IN_W-1:0] a45_q, a135_q;

  function automatic logic signed [VW-1:0] fit_ref(input wide_t a);
    if (a > lim_hi(VW)) return {1'b0, {(VW-1){1'b1}}};
    if (a < lim_lo(VW)) return {1'b1, {(VW-1){1'b0}}};
    return a[VW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_valid <= 1'b0;
      s_hold  <= 1'b0;
      s_clr   <= 1'b0;
      s_mu    <= '0;
      r_re    <= '0;
      r_im    <= '0;
      a45_q   <= '0;
      a135_q  <= '0;
    end else begin
      s_valid <= in_valid;
      s_hold  <= hold_w;
      s_clr   <= clr_w;
      s_mu    <= mu_shift;
      if (in_valid) begin
        r_re   <= p000;
        r_im   <= p090;
        a45_q  <= p045;
        a135_q <= p135;
      end
    end
  end

  wide_t rot_re, rot_im;
  always_comb begin
    rot_re = scale_isqrt2(wide_t'(a45_q) + wide_t'(a135_q));
    rot_im = scale_isqrt2(wide_t'(a135_q) - wide_t'(a45_q));
  end

  assign v_re = fit_ref(wide_t'(r_re) - rot_re);
  assign v_im = fit_ref(wide_t'(r_im) - rot_im);
endmodule

// File: rtl/harm_estimate.sv
module harm_estimate
  import harm_pkg::*;
#(
  parameter int IN_W = 12,
  parameter int VW   = 14,
  parameter int W_W  = 18,
  parameter int WF   = 16
) (
  input  logic signed [IN_W-1:0] r_re,
  input  logic signed [IN_W-1:0] r_im,
  input  logic signed [VW-1:0]   v_re,
  input  logic signed [VW-1:0]   v_im,
  input  logic signed [W_W-1:0]  w1_re,
  input  logic signed [W_W-1:0]  w1_im,
  input  logic signed [W_W-1:0]  w2_re,
  input  logic signed [W_W-1:0]  w2_im,
  output wide_t                  e_re,
  output wide_t                  e_im
);
  wide_t vr, vi, acc_re, acc_im;

  always_comb begin
    vr = wide_t'(v_re);
    vi = wide_t'(v_im);
    // w1*v plus w2*conj(v)
    acc_re = wide_t'(w1_re) * vr - wide_t'(w1_im) * vi
           + wide_t'(w2_re) * vr + wide_t'(w2_im) * vi;
    acc_im = wide_t'(w1_re) * vi + wide_t'(w1_im) * vr
           + wide_t'(w2_im) * vr - wide_t'(w2_re) * vi;
    e_re = wide_t'(r_re) - (acc_re >>> WF);
    e_im = wide_t'(r_im) - (acc_im >>> WF);
  end
endmodule

// File: rtl/harm_lms.sv
module harm_lms
  import harm_pkg::*;
#(
  parameter int VW         = 14,
  parameter int W_W        = 18,
  parameter int MU_W       = 4,
  parameter int GRAD_SHIFT = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  input  logic                  s_hold,
  input  logic                  s_clr,
  input  logic [MU_W-1:0]       s_mu,
  input  logic signed [VW-1:0]  v_re,
  input  logic signed [VW-1:0]  v_im,
  input  wide_t                 e_re,
  input  wide_t                 e_im,
  output logic signed [W_W-1:0] w1_re,
  output logic signed [W_W-1:0] w1_im,
  output logic signed [W_W-1:0] w2_re,
  output logic signed [W_W-1:0] w2_im
);
  localparam int SH_W = 8;

  function automatic logic signed [W_W-1:0] sat_w(input wide_t a);
    if (a > lim_hi(W_W)) return {1'b0, {(W_W-1){1'b1}}};
    if (a < lim_lo(W_W)) return {1'b1, {(W_W-1){1'b0}}};
    return a[W_W-1:0];
  endfunction

  logic            clr_en, upd_en;
  logic [SH_W-1:0] shamt;
  wide_t           grad [4];
  logic signed [W_W-1:0] w_q [4];

  assign clr_en = s_clr;
  assign upd_en = s_valid && !s_hold && !s_clr;
  assign shamt  = SH_W'(GRAD_SHIFT) + SH_W'(s_mu);

  always_comb begin
    // e*conj(v) feeds w1, e*v feeds w2
    grad[0] = e_re * wide_t'(v_re) + e_im * wide_t'(v_im);
    grad[1] = e_im * wide_t'(v_re) - e_re * wide_t'(v_im);
    grad[2] = e_re * wide_t'(v_re) - e_im * wide_t'(v_im);
    grad[3] = e_re * wide_t'(v_im) + e_im * wide_t'(v_re);
  end

  for (genvar k = 0; k < 4; k++) begin : g_w
    wide_t nxt;
    assign nxt = wide_t'(w_q[k]) + (grad[k] >>> shamt);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      w_q[k] <= '0;
      else if (clr_en) w_q[k] <= '0;
      else if (upd_en) w_q[k] <= sat_w(nxt);
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> (w_q[k] == '0)); // R7
    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (s_hold && !clr_en) |=> $stable(w_q[k])); // R8
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_valid && !clr_en) |=> $stable(w_q[k])); // R10
  end

  assign w1_re = w_q[0];
  assign w1_im = w_q[1];
  assign w2_re = w_q[2];
  assign w2_im = w_q[3];
endmodule

// File: rtl/harm_canceller.sv
module harm_canceller
  import harm_pkg::*;
#(
  parameter int IN_W       = 12,
  parameter int W_W        = 18,
  parameter int WF         = 16,
  parameter int OUT_W      = 16,
  parameter int MU_W       = 4,
  parameter int GRAD_SHIFT = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  p000,
  input  logic signed [IN_W-1:0]  p045,
  input  logic signed [IN_W-1:0]  p090,
  input  logic signed [IN_W-1:0]  p135,
  input  logic [MU_W-1:0]         mu_shift,
  input  logic                    hold_w,
  input  logic                    clr_w,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int VW = IN_W + 2;

  function automatic logic signed [OUT_W-1:0] sat_out(input wide_t a);
    if (a > lim_hi(OUT_W)) return {1'b0, {(OUT_W-1){1'b1}}};
    if (a < lim_lo(OUT_W)) return {1'b1, {(OUT_W-1){1'b0}}};
    return a[OUT_W-1:0];
  endfunction

  logic                  s_valid, s_hold, s_clr;
  logic [MU_W-1:0]       s_mu;
  logic signed [IN_W-1:0] r_re, r_im;
  logic signed [VW-1:0]  v_re, v_im;
  logic signed [W_W-1:0] w1_re, w1_im, w2_re, w2_im;
  wide_t                 e_re, e_im;

  harm_ref_gen #(.IN_W(IN_W), .MU_W(MU_W), .VW(VW)) u_ref (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .p000(p000), .p045(p045), .p090(p090), .p135(p135),
    .mu_shift(mu_shift), .hold_w(hold_w), .clr_w(clr_w),
    .s_valid(s_valid), .s_hold(s_hold), .s_clr(s_clr), .s_mu(s_mu),
    .r_re(r_re), .r_im(r_im), .v_re(v_re), .v_im(v_im)
  );

  harm_estimate #(.IN_W(IN_W), .VW(VW), .W_W(W_W), .WF(WF)) u_est (
    .r_re(r_re), .r_im(r_im), .v_re(v_re), .v_im(v_im),
    .w1_re(w1_re), .w1_im(w1_im), .w2_re(w2_re), .w2_im(w2_im),
    .e_re(e_re), .e_im(e_im)
  );

  harm_lms #(.VW(VW), .W_W(W_W), .MU_W(MU_W), .GRAD_SHIFT(GRAD_SHIFT)) u_lms (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_hold(s_hold),
    .s_clr(s_clr), .s_mu(s_mu), .v_re(v_re), .v_im(v_im),
    .e_re(e_re), .e_im(e_im),
    .w1_re(w1_re), .w1_im(w1_im), .w2_re(w2_re), .w2_im(w2_im)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s_valid;
      if (s_valid) begin
        out_i <= sat_out(e_re);
        out_q <= sat_out(e_im);
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    s_valid |=> out_valid); // R9
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> !out_valid); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s_valid |=> ($stable(out_i) && $stable(out_q))); // R10
endmodule

// File: tb/harm_canceller_tb.sv
`timescale 1ns/1ps
module harm_canceller_tb;
  localparam int OW = 14;
  localparam int NV = 16;
  // p000, p045, p090, p135, mu, freeze
  localparam int VEC [NV][6] = '{
    '{ 1200,   850,  -300,   400,  3, 0},
    '{ -950,  -600,   700,  -200,  2, 0},
    '{ 1800,  1500,   100,   900,  1, 0},
    '{ -400,   300, -1500,  -900,  4, 0},
    '{ 2047,  2047,  2047,  2047,  0, 0},
    '{-2048, -2048, -2048, -2048,  0, 0},
    '{  500,  -800,  1300,  1100,  2, 0},
    '{-1700,   600,  -200,  1900,  3, 0},
    '{  300,   200,   900,  1000,  5, 0},
    '{-1200,  1700,   400, -1600,  1, 0},
    '{ 1500, -1000, -1800,   300,  0, 0},
    '{    0,     0,     0,     0,  0, 0},
    '{  700,  1400,  -700,   100,  2, 1},
    '{ -300, -1900,  1600,   700,  6, 0},
    '{ 1100,    50, -1100,   -50, 15, 0},
    '{-2048,  2047,  2047, -2048,  0, 0}
  };

  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, hold_w = 1'b0, clr_w = 1'b0;
  logic signed [11:0] p000 = '0, p045 = '0, p090 = '0, p135 = '0;
  logic [3:0] mu_shift = '0;
  logic out_valid;
  logic signed [OW-1:0] out_i, out_q;

  always #5 clk = ~clk;

  harm_canceller #(.OUT_W(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .p000(p000), .p045(p045), .p090(p090), .p135(p135),
    .mu_shift(mu_shift), .hold_w(hold_w), .clr_w(clr_w),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0, n_bad = 0, wsat_hits = 0, osat_hits = 0;
  longint mw [4] = '{0, 0, 0, 0};
  bit p1_v = 0, p2_v = 0;
  longint p1_i = 0, p1_q = 0, p2_i = 0, p2_q = 0, hold_i = 0, hold_q = 0;
  string p1_t = "", p2_t = "";

  task automatic chk(input longint act, input longint exp, input string tag, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint fdiv(input longint a, input int sh);
    longint d, q;
    d = longint'(1) << sh;
    q = a / d;
    if (a < 0 && q * d != a) q = q - 1;
    return q;
  endfunction

  function automatic longint clampw(input longint a, input int bits, inout int hits);
    longint hi, lo;
    hi = (longint'(1) << (bits - 1)) - 1;
    lo = -(longint'(1) << (bits - 1));
    if (a > hi) begin hits++; return hi; end
    if (a < lo) begin hits++; return lo; end
    return a;
  endfunction

  // one clock per call, called at a falling edge
  task automatic step(input bit vld, input int a0, input int a45, input int a90,
                      input int a135, input int m, input bit fz, input bit cl,
                      input string tag);
    longint rr, ri, tr, ti, vr, vi, yr, yi, er, ei;
    longint g [4];
    chk(longint'(out_valid), longint'(p2_v), "R9", "out_valid");
    if (p2_v) begin hold_i = p2_i; hold_q = p2_q; end
    chk(longint'(out_i), hold_i, p2_v ? p2_t : "R10", "out_i");
    chk(longint'(out_q), hold_q, p2_v ? p2_t : "R10", "out_q");
    p2_v = p1_v; p2_i = p1_i; p2_q = p1_q; p2_t = p1_t;
    p1_v = vld; p1_t = tag;
    if (vld) begin
      rr = a0; ri = a90;
      tr = fdiv(longint'(a45 + a135) * 23170 + 16384, 15);
      ti = fdiv(longint'(a135 - a45) * 23170 + 16384, 15);
      vr = rr - tr; vi = ri - ti;
      yr = fdiv(mw[0]*vr - mw[1]*vi + mw[2]*vr + mw[3]*vi, 16);
      yi = fdiv(mw[0]*vi + mw[1]*vr + mw[3]*vr - mw[2]*vi, 16);
      er = rr - yr; ei = ri - yi;
      p1_i = clampw(er, OW, osat_hits);
      p1_q = clampw(ei, OW, osat_hits);
      if (!fz && !cl) begin
        g[0] = er*vr + ei*vi; g[1] = ei*vr - er*vi;
        g[2] = er*vr - ei*vi; g[3] = er*vi + ei*vr;
        for (int k = 0; k < 4; k++)
          mw[k] = clampw(mw[k] + fdiv(g[k], 12 + m), 18, wsat_hits);
      end
    end
    if (cl) for (int k = 0; k < 4; k++) mw[k] = 0;
    in_valid = vld; p000 = 12'(a0); p045 = 12'(a45); p090 = 12'(a90); p135 = 12'(a135);
    mu_shift = 4'(m); hold_w = fz; clr_w = cl;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #1000000;
    n_chk++; n_bad++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk(longint'(out_valid), 0, "R9", "reset out_valid");
    chk(longint'(out_i), 0, "R9", "reset out_i");
    chk(longint'(out_q), 0, "R9", "reset out_q");
    rst_n = 1'b1;
    @(negedge clk);
    // R1: zero weights pass the main sample, frozen so weights stay zero
    step(1,  1234, -2048,  -567,  2047, 0, 1, 0, "R1");
    step(1, -2048,   999,  2047, -1500, 0, 1, 0, "R1");
    step(1,  2047,  2047, -2048, -2048, 0, 1, 0, "R1");
    step(1,     5,  -700,   -33,   812, 0, 1, 0, "R1");
    // R2 R3 R5: table walked back to back with adaptation
    for (int n = 0; n < NV; n++)
      step(1, VEC[n][0], VEC[n][1], VEC[n][2], VEC[n][3], VEC[n][4], VEC[n][5] != 0, 0,
           "R2 R3 R5");
    // R10: idle cycles between samples
    step(0, 1900, -1900, 1900, -1900, 0, 0, 0, "R10");
    step(0, -800, 800, 300, 300, 0, 0, 0, "R10");
    step(1, 600, 400, -900, 250, 3, 1, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // R8: freeze keeps weights, repeated input gives repeated output
    step(1, 1500, 700, -400, 1100, 0, 1, 0, "R8");
    step(1, 1500, 700, -400, 1100, 0, 1, 0, "R8");
    step(1, 1500, 700, -400, 1100, 0, 1, 0, "R8");
    // R7: clear with a sample, then zero weights
    step(1, -900, 1300, 450, -600, 2, 0, 1, "R7");
    step(1, 321, 1800, -654, -1200, 0, 1, 0, "R7");
    step(1, 1600, 300, -1600, 900, 1, 0, 0, "R7");
    step(1, -1400, -200, 1700, 500, 1, 0, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R7");
    step(1, 777, -1234, -888, 1500, 0, 1, 0, "R7");
    // R6: steady weak reference drives the weights to their limits
    for (int n = 0; n < 2500; n++)
      step(1, 2047, 1165, 0, 1165, 0, 0, 0, "R6");
    n_chk++;
    if (wsat_hits == 0) begin
      n_bad++;
      $display("FAIL R6 weight clamp reached: actual %0d expected >0", wsat_hits);
    end
    // R4: large reference against saturated weights clips the output
    step(1, -2048, 2047, 0, 2047, 0, 1, 0, "R4");
    step(1, 2047, -2048, 0, -2048, 0, 1, 0, "R4");
    step(1, 1000, 1500, -1500, -300, 0, 1, 0, "R4");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, "R10");
    n_chk++;
    if (osat_hits == 0) begin
      n_bad++;
      $display("FAIL R4 output clamp reached: actual %0d expected >0", osat_hits);
    end
    summary();
    $finish;
  end
endmodule